// File: doc/BRIEF.md
# Auxiliary Switch Soft-Switching Timing Generator

This block produces the gate drive for the auxiliary clamp switch of a soft-switched three-phase boost rectifier. It also produces the reset pulse that starts each on period of the one-cycle modulator core. Both are derived from one switching-cycle tick and counted on a fast clock. Each accepted tick starts a switching cycle. The auxiliary gate drops at once. One dead interval later a single-cycle reset pulse tells the core to turn its main switches on. A second dead interval after that pulse, the auxiliary gate rises again, well before the modulated switches may turn off. This leaves the resonant tank time to pull the bridge voltage to zero before every main turn-on.

Internally, two counter-based delay stages, each one dead interval long, act as two delayed copies of the cycle clock. The auxiliary drive is the combination of their windows. The reset pulse is the shortened edge taken at the joint between the two windows, so the core itself needs no change. The dead interval is a setting in fast-clock cycles. It is clamped to a legal range and captured when a cycle starts.

Top module: `aux_gate_timer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `aux_gate` is 1 and `core_rst` is 0.
- R2: A `cycle_tick` sampled on a rising edge while `aux_gate` is 1 drives `aux_gate` to 0 right after that edge.
- R3: `core_rst` is 1 for exactly one fast-clock cycle, starting D edges after the edge at which `aux_gate` fell, where D is the effective dead interval.
- R4: `aux_gate` returns to 1 D edges after the edge that raised `core_rst`, so the gate stays low for exactly 2·D cycles.
- R5: A `cycle_tick` sampled while `aux_gate` is 0 is ignored: it neither lengthens the low period nor adds a second `core_rst` pulse.
- R6: A `dead_cfg` value of 0 is treated as D = 1.
- R7: A `dead_cfg` value at or above CYC_NOM/2 is treated as D = CYC_NOM/2 − 1.
- R8: D is captured at the accepting tick; changing `dead_cfg` while `aux_gate` is low does not alter that cycle's timing.
- R9: `core_rst` is never 1 while `aux_gate` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast counting clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | One-cycle pulse marking the start of a switching cycle |
| dead_cfg | input | DW | Requested dead interval in fast-clock cycles |
| aux_gate | output | 1 | Auxiliary switch gate drive, 1 = on |
| core_rst | output | 1 | Single-cycle reset pulse for the one-cycle core |

## Verification
The bench builds the block with CYC_NOM = 40 and DW = 8. The clamp ceiling of 19 then lies well inside the 8-bit setting range, so requests from 0 up to 255 test both clamp limits. At the same time a full cycle of up to 38 low cycles stays short, which allows thousands of random cycles. A small nominal period also keeps random tick gaps short enough that many ticks land inside the gate-low window, so the rule that ignores ticks during a cycle is exercised often.

// File: rtl/agt_pkg.sv
package agt_pkg;
  localparam int unsigned AGT_STAGES = 2;
  localparam int unsigned AGT_STAGE_LEAD = 0;
  localparam int unsigned AGT_STAGE_TRAIL = 1;
endpackage

// File: rtl/agt_dead_sel.sv
module agt_dead_sel #(
  parameter int unsigned DW   = 8,
  parameter int unsigned HALF = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] cfg,
  output logic [DW-1:0] dead_now,
  output logic [DW-1:0] dead_hold
);
  localparam logic [DW-1:0] CEIL  = DW'(HALF - 1);
  localparam logic [DW-1:0] LIMIT = DW'(HALF);

  always_comb begin
    if (cfg == '0)          dead_now = DW'(1);
    else if (cfg >= LIMIT)  dead_now = CEIL;
    else                    dead_now = cfg;
  end

  always_ff @(posedge clk) begin
    if (rst)          dead_hold <= DW'(1);
    else if (capture) dead_hold <= dead_now;
  end

  // R6 / R7: the captured interval is always inside the legal range
  p_hold_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (dead_hold != '0) && (dead_hold <= CEIL));
endmodule

// File: rtl/agt_interval.sv
module agt_interval #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] len,
  output logic          active,
  output logic          done
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= len;
    end else if (active) begin
      if (cnt == DW'(1)) active <= 1'b0;
      cnt <= cnt - DW'(1);
    end
  end

  assign done = active && (cnt == DW'(1));

  // R6: a window is never launched with a zero length
  p_start_len_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> (len != '0));
  p_cnt_live_r3: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
endmodule

// File: rtl/agt_pulse_shape.sv
module agt_pulse_shape (
  input  logic clk,
  input  logic rst,
  input  logic joint,
  input  logic gate_low,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= joint & gate_low;
  end

  // R3: the shaped pulse never lasts two cycles
  p_pulse_narrow_r3: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/aux_gate_timer.sv
module aux_gate_timer #(
  parameter int unsigned CYC_NOM = 200,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cycle_tick,
  input  logic [DW-1:0] dead_cfg,
  output logic          aux_gate,
  output logic          core_rst
);
  import agt_pkg::*;

  localparam int unsigned HALF = CYC_NOM / 2;

  logic                gate_q;
  logic                accept;
  logic [DW-1:0]       dead_now;
  logic [DW-1:0]       dead_hold;
  logic [AGT_STAGES-1:0] st_start;
  logic [AGT_STAGES-1:0] st_active;
  logic [AGT_STAGES-1:0] st_done;
  logic [DW-1:0]       st_len [AGT_STAGES];

  assign accept = cycle_tick & gate_q;

  agt_dead_sel #(.DW(DW), .HALF(HALF)) u_dead (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept),
    .cfg      (dead_cfg),
    .dead_now (dead_now),
    .dead_hold(dead_hold)
  );

  assign st_start[AGT_STAGE_LEAD]  = accept;
  assign st_len[AGT_STAGE_LEAD]    = dead_now;
  assign st_start[AGT_STAGE_TRAIL] = st_done[AGT_STAGE_LEAD];
  assign st_len[AGT_STAGE_TRAIL]   = dead_hold;

  for (genvar s = 0; s < AGT_STAGES; s++) begin : g_stage
    agt_interval #(.DW(DW)) u_win (
      .clk   (clk),
      .rst   (rst),
      .start (st_start[s]),
      .len   (st_len[s]),
      .active(st_active[s]),
      .done  (st_done[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                          gate_q <= 1'b1;
    else if (accept)                  gate_q <= 1'b0;
    else if (st_done[AGT_STAGE_TRAIL]) gate_q <= 1'b1;
  end

  agt_pulse_shape u_shape (
    .clk     (clk),
    .rst     (rst),
    .joint   (st_done[AGT_STAGE_LEAD]),
    .gate_low(~gate_q),
    .pulse   (core_rst)
  );

  assign aux_gate = gate_q;

  // R9: reset pulse only inside the gate-low window
  p_pulse_gate_low_r9: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> !aux_gate);
  // R2: an accepted tick drops the gate on the next cycle
  p_fall_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (aux_gate && cycle_tick) |=> !aux_gate);
  // R5: while low, the gate holds unless the trailing window ends
  p_hold_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!aux_gate && !st_done[AGT_STAGE_TRAIL]) |=> !aux_gate);
  // R4: the gate rises only when the trailing window closes
  p_rise_on_trail_r4: assert property (@(posedge clk) disable iff (rst)
    (!aux_gate && st_done[AGT_STAGE_TRAIL]) |=> aux_gate);
  // R8: the two windows never overlap
  p_stage_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st_active));
endmodule

// File: tb/sim_aux_gate_timer.sv
module sim_aux_gate_timer;
  localparam int unsigned CYC_NOM = 40;
  localparam int unsigned DW      = 8;
  localparam int unsigned HALF    = CYC_NOM / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cycle_tick = 1'b0;
  logic [DW-1:0] dead_cfg = '0;
  logic          aux_gate;
  logic          core_rst;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit track  = 1'b0;

  // lockstep reference built from the requirements
  bit m_gate = 1'b1;
  bit m_pulse = 1'b0;
  int m_t = 0;
  int m_d = 1;

  always #10 clk = ~clk;

  aux_gate_timer #(.CYC_NOM(CYC_NOM), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cycle_tick(cycle_tick), .dead_cfg(dead_cfg),
    .aux_gate(aux_gate), .core_rst(core_rst)
  );

  function automatic int eff_dead(input int v);
    if (v == 0) return 1;
    if (v >= int'(HALF)) return int'(HALF) - 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_gate = 1'b1; m_pulse = 1'b0; m_t = 0;
    end else if (m_gate && cycle_tick) begin
      m_gate = 1'b0; m_pulse = 1'b0; m_t = 0; m_d = eff_dead(int'(dead_cfg));
    end else if (!m_gate) begin
      m_t++;
      m_pulse = (m_t == m_d);
      if (m_t == 2 * m_d) m_gate = 1'b1;
    end else begin
      m_pulse = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (track) begin
      check(aux_gate == m_gate, "R2/R4 gate vs model", int'(aux_gate), int'(m_gate));
      check(core_rst == m_pulse, "R3/R5 pulse vs model", int'(core_rst), int'(m_pulse));
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one accepted cycle; optional mid-cycle cfg change and extra ticks
  task automatic run_cycle(input int cfg, input int new_cfg, input bit poke,
                           input string req);
    int low = 0;
    int pos = -1;
    int npulse = 0;
    int d = eff_dead(cfg);
    while (!aux_gate) @(negedge clk);
    dead_cfg = DW'(cfg);
    cycle_tick = 1'b1;
    @(negedge clk);
    cycle_tick = 1'b0;
    while (!aux_gate && low < 200) begin
      if (core_rst) begin npulse++; pos = low; end
      low++;
      if (poke) begin
        dead_cfg = DW'(new_cfg);
        cycle_tick = (low % 3 == 1);
      end
      @(negedge clk);
    end
    cycle_tick = 1'b0;
    check(low == 2 * d, {req, " low length"}, low, 2 * d);
    check(pos == d, {req, " pulse offset"}, pos, d);
    check(npulse == 1, {req, " pulse count"}, npulse, 1);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(aux_gate == 1'b1, "R1 gate in reset", int'(aux_gate), 1);
    check(core_rst == 1'b0, "R1 pulse in reset", int'(core_rst), 0);
    rst = 1'b0;
    @(negedge clk);
    check(aux_gate == 1'b1, "R1 gate after reset", int'(aux_gate), 1);
    check(core_rst == 1'b0, "R1 pulse after reset", int'(core_rst), 0);
    track = 1'b1;
    @(negedge clk);

    run_cycle(5, 5, 1'b0, "R2 R3 R4 nominal");
    run_cycle(0, 0, 1'b0, "R6 zero");
    run_cycle(1, 1, 1'b0, "R3 minimum");
    run_cycle(19, 19, 1'b0, "R7 ceiling");
    run_cycle(20, 20, 1'b0, "R7 at half");
    run_cycle(255, 255, 1'b0, "R7 max");
    run_cycle(7, 2, 1'b1, "R8 R5 change and extra ticks");
    run_cycle(3, 250, 1'b1, "R8 R5 change upward");
    // back-to-back: tick held high keeps restarting right after each rise
    dead_cfg = DW'(4);
    cycle_tick = 1'b1;
    repeat (40) @(negedge clk);
    cycle_tick = 1'b0;
    repeat (20) @(negedge clk);

    for (int n = 0; n < 3000; n++) begin
      dead_cfg = DW'($urandom_range(0, 60));
      cycle_tick = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    cycle_tick = 1'b0;
    repeat (50) @(negedge clk);
    check(aux_gate == 1'b1, "R4 idle gate high", int'(aux_gate), 1);
    check(core_rst == 1'b0, "R9 idle pulse low", int'(core_rst), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule